// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block is the controller-side state machine that takes a double-data-rate DRAM from power-on to normal operation. After reset it keeps the device's power-down pin low and the command bus deselected while the clock settles for a stable-clock interval. The length of that interval is a cycle count derived from the clock frequency. It then releases power-down and waits a power-down-exit interval. Next it programs the extended mode register and then the mode register, with a fixed spacing between register writes. After that it issues a parameterised number of auto-refresh commands, each followed by the refresh cycle time.

The extended mode register write turns the DLL on, selects the output driver strength and leaves the impedance calibration mode. The mode register write carries the CAS latency, burst type and burst length, which come from static inputs. A counter that starts on the extended mode register write must reach a minimum count before the ready flag may rise. Ready, once high, stays high until reset. The data-bus output enable stays low throughout, so DQ and DQS remain high-impedance.

Top module: `dram_init_seq`

## Requirements
- R1: While rst_ni is low: pd_o=0, dq_oe_o=0, ready_o=0, cmd_o=4'b1111 (deselect), ba_o=0, addr_o=0.
- R2: Counting cycle t=0 as the first cycle after reset release, pd_o stays 0 and cmd_o stays deselect for S=CLK_MHZ*STABLE_US cycles (t<S).
- R3: pd_o is 1 from t=S onward and never falls again before a reset. The cycles S..S+T_PDEX-1 carry deselect only.
- R4: At t=E=S+T_PDEX a single extended mode register write is issued: cmd_o=4'b0000 ({cs_n,ras_n,cas_n,we_n}), ba_o=2'b01, addr_o[0]=0 (DLL enabled), addr_o[1]=drv_strength_i, addr_o[9:7]=0 (calibration exit), all other address bits 0.
- R5: At t=E+T_RSC a mode register write is issued: cmd_o=4'b0000, ba_o=2'b00, addr_o[2:0]=burst_len_i, addr_o[3]=burst_type_i, addr_o[6:4]=cas_lat_i, all other address bits 0.
- R6: N_REF auto-refresh commands (cmd_o=4'b0001, ba_o=0, addr_o=0) are issued at t=E+2*T_RSC+k*T_REFC for k=0..N_REF-1.
- R7: ready_o rises exactly at t=max(E+GATE_CLK, E+2*T_RSC+N_REF*T_REFC) and is 0 at every earlier cycle.
- R8: dq_oe_o is 0 on every cycle.
- R9: ready_o, once 1, stays 1 until reset. An asynchronous reset at any point restarts the sequence from R1/R2 with the new static field values.
- R10: Every cycle not named in R4 to R6 carries deselect with ba_o=0 and addr_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cas_lat_i | input | 3 | CAS latency code for the mode register |
| burst_type_i | input | 1 | Burst type bit for the mode register |
| burst_len_i | input | 3 | Burst length code for the mode register |
| drv_strength_i | input | 1 | Driver strength bit for the extended mode register |
| cmd_o | output | 4 | Command {cs_n,ras_n,cas_n,we_n} |
| ba_o | output | 2 | Bank address, selects the mode register |
| addr_o | output | ADDR_W | Address / op-code bus |
| pd_o | output | 1 | Power-down pin, high means active |
| dq_oe_o | output | 1 | Data and strobe output enable |
| ready_o | output | 1 | Initialization complete |

## Verification
A wrong state or counter value shows up on the command bus as a command that is shifted, missing or repeated. A stuck or early power-down release shows up as pd_o rising on a cycle other than S. Because the bench predicts every output on every cycle from the schedule above, the mismatch is reported in the cycle where the first wrong command, op-code bit or power-down level appears. A gate counter that is off by one moves the ready edge by one cycle and is caught on that edge. A checker also bounds ready against its own count of cycles since the extended register write.

// File: rtl/dinit_pkg.sv
package dinit_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_DESL = 4'b1111;
  localparam logic [3:0] CMD_MRS  = 4'b0000;
  localparam logic [3:0] CMD_REF  = 4'b0001;

  localparam logic [1:0] BA_MR  = 2'b00;
  localparam logic [1:0] BA_EMR = 2'b01;

  typedef enum logic [1:0] {
    CK_DESL,
    CK_EMRS,
    CK_MRS,
    CK_REF
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_STABLE,
    ST_PDEX,
    ST_EMRS,
    ST_MRS,
    ST_REF,
    ST_WAIT,
    ST_DONE
  } init_state_e;
endpackage

// File: rtl/dinit_cnt.sv
module dinit_cnt #(
  parameter int W   = 8,
  parameter int MAX = 255
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MaxVal = W'(MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    q_o <= '0;
    else if (clr_i)                 q_o <= '0;
    else if (en_i && q_o != MaxVal) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/dinit_opcode.sv
module dinit_opcode
  import dinit_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  cmd_kind_e         kind_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              burst_type_i,
  input  logic [2:0]        burst_len_i,
  input  logic              drv_strength_i,
  output logic [3:0]        cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] emr_code, mr_code;

  // Field positions are decoded by the device, so they are fixed.
  generate
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bits
      if (b == 1) begin : g_drv
        assign emr_code[b] = drv_strength_i;
      end else begin : g_zero
        assign emr_code[b] = 1'b0; // A0=0 DLL on, A9:A7=0 calibration exit
      end
      if (b < 3) begin : g_bl
        assign mr_code[b] = burst_len_i[b];
      end else if (b == 3) begin : g_bt
        assign mr_code[b] = burst_type_i;
      end else if (b < 7) begin : g_cl
        assign mr_code[b] = cas_lat_i[b-4];
      end else begin : g_rsv
        assign mr_code[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    cmd_o  = CMD_DESL;
    ba_o   = '0;
    addr_o = '0;
    unique case (kind_i)
      CK_EMRS: begin cmd_o = CMD_MRS; ba_o = BA_EMR; addr_o = emr_code; end
      CK_MRS:  begin cmd_o = CMD_MRS; ba_o = BA_MR;  addr_o = mr_code;  end
      CK_REF:  cmd_o = CMD_REF;
      default: ;
    endcase
  end
endmodule

// File: rtl/dinit_fsm.sv
module dinit_fsm
  import dinit_pkg::*;
#(
  parameter int STABLE_CYC = 40000,
  parameter int T_PDEX     = 2,
  parameter int T_RSC      = 2,
  parameter int T_REFC     = 12,
  parameter int N_REF      = 2,
  parameter int GATE_CLK   = 200,
  parameter int CW         = 16,
  parameter int GW         = 8,
  parameter int RW         = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [GW-1:0] gcnt_i,
  output logic          cnt_clr_o,
  output logic          cnt_en_o,
  output logic          gate_en_o,
  output cmd_kind_e     kind_o,
  output logic          pd_o,
  output logic          ready_o
);
  init_state_e st_q, st_d;
  logic [RW-1:0] ref_q, ref_d;
  logic [CW-1:0] dur;
  logic          last, gate_done;

  assign gate_done = (gcnt_i == GW'(GATE_CLK));

  always_comb begin
    unique case (st_q)
      ST_STABLE:      dur = CW'(STABLE_CYC);
      ST_PDEX:        dur = CW'(T_PDEX);
      ST_EMRS, ST_MRS: dur = CW'(T_RSC);
      ST_REF:         dur = CW'(T_REFC);
      default:        dur = CW'(1);
    endcase
  end

  assign last = (cnt_i == dur - 1'b1);

  always_comb begin
    st_d  = st_q;
    ref_d = ref_q;
    unique case (st_q)
      ST_STABLE: if (last) st_d = ST_PDEX;
      ST_PDEX:   if (last) st_d = ST_EMRS;
      ST_EMRS:   if (last) st_d = ST_MRS;
      ST_MRS:    if (last) st_d = ST_REF;
      ST_REF: if (last) begin
        if (ref_q == RW'(N_REF - 1)) st_d = ST_WAIT;
        else                         ref_d = ref_q + 1'b1;
      end
      ST_WAIT:   if (gate_done) st_d = ST_DONE;
      default:   ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_STABLE;
      ref_q <= '0;
    end else begin
      st_q  <= st_d;
      ref_q <= ref_d;
    end
  end

  assign cnt_en_o  = (st_q != ST_WAIT) && (st_q != ST_DONE);
  assign cnt_clr_o = cnt_en_o && last;
  assign gate_en_o = (st_q != ST_STABLE) && (st_q != ST_PDEX);

  // Commands go out in the first cycle of their spacing window.
  always_comb begin
    kind_o = CK_DESL;
    if (cnt_i == '0) begin
      unique case (st_q)
        ST_EMRS: kind_o = CK_EMRS;
        ST_MRS:  kind_o = CK_MRS;
        ST_REF:  kind_o = CK_REF;
        default: kind_o = CK_DESL;
      endcase
    end
  end

  assign pd_o    = (st_q != ST_STABLE);
  assign ready_o = (st_q == ST_DONE) || ((st_q == ST_WAIT) && gate_done);
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dinit_pkg::*;
#(
  parameter int CLK_MHZ   = 200,
  parameter int STABLE_US = 200,
  parameter int T_PDEX    = 2,
  parameter int T_RSC     = 2,
  parameter int T_REFC    = 12,
  parameter int N_REF     = 2,
  parameter int GATE_CLK  = 200,
  parameter int ADDR_W    = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cas_lat_i,
  input  logic              burst_type_i,
  input  logic [2:0]        burst_len_i,
  input  logic              drv_strength_i,
  output logic [3:0]        cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pd_o,
  output logic              dq_oe_o,
  output logic              ready_o
);
  localparam int StableCyc = CLK_MHZ * STABLE_US;
  localparam int M1   = (StableCyc > T_REFC) ? StableCyc : T_REFC;
  localparam int M2   = (T_PDEX > T_RSC) ? T_PDEX : T_RSC;
  localparam int CMax = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(CMax + 1);
  localparam int GW   = $clog2(GATE_CLK + 1);
  localparam int RW   = (N_REF > 1) ? $clog2(N_REF) : 1;

  logic [CW-1:0] cnt;
  logic [GW-1:0] gcnt;
  logic          cnt_clr, cnt_en, gate_en;
  cmd_kind_e     kind;

  dinit_cnt #(.W(CW), .MAX(CMax)) u_step_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .q_o   (cnt)
  );

  dinit_cnt #(.W(GW), .MAX(GATE_CLK)) u_gate_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (1'b0),
    .en_i  (gate_en),
    .q_o   (gcnt)
  );

  dinit_fsm #(
    .STABLE_CYC(StableCyc), .T_PDEX(T_PDEX), .T_RSC(T_RSC), .T_REFC(T_REFC),
    .N_REF(N_REF), .GATE_CLK(GATE_CLK), .CW(CW), .GW(GW), .RW(RW)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt),
    .gcnt_i   (gcnt),
    .cnt_clr_o(cnt_clr),
    .cnt_en_o (cnt_en),
    .gate_en_o(gate_en),
    .kind_o   (kind),
    .pd_o     (pd_o),
    .ready_o  (ready_o)
  );

  dinit_opcode #(.ADDR_W(ADDR_W)) u_opcode (
    .kind_i        (kind),
    .cas_lat_i     (cas_lat_i),
    .burst_type_i  (burst_type_i),
    .burst_len_i   (burst_len_i),
    .drv_strength_i(drv_strength_i),
    .cmd_o         (cmd_o),
    .ba_o          (ba_o),
    .addr_o        (addr_o)
  );

  assign dq_oe_o = 1'b0;
endmodule

// File: rtl/dinit_chk.sv
module dinit_chk #(
  parameter int ADDR_W   = 14,
  parameter int GATE_CLK = 200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        cmd_o,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              pd_o,
  input logic              dq_oe_o,
  input logic              ready_o
);
  logic seen_emrs;
  int   since_emrs;
  logic emrs_now;

  assign emrs_now = (cmd_o == 4'b0000) && (ba_o == 2'b01);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_emrs  <= 1'b0;
      since_emrs <= 0;
    end else if (emrs_now && !seen_emrs) begin
      seen_emrs  <= 1'b1;
      since_emrs <= 1;
    end else if (seen_emrs && since_emrs < GATE_CLK) begin
      since_emrs <= since_emrs + 1;
    end
  end

  AST_CMD_NEEDS_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != 4'b1111) |-> pd_o); // R2
  AST_PD_NO_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |=> pd_o); // R3
  AST_EMRS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emrs_now |-> (addr_o[0] == 1'b0 && addr_o[9:7] == 3'b000)); // R4
  AST_READY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (seen_emrs && since_emrs >= GATE_CLK)); // R7
  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o); // R8
  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R9
  AST_DESL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 4'b1111) |-> (ba_o == 2'b00 && addr_o == '0)); // R10
endmodule

bind dram_init_seq dinit_chk #(.ADDR_W(ADDR_W), .GATE_CLK(GATE_CLK)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cmd_o  (cmd_o),
  .ba_o   (ba_o),
  .addr_o (addr_o),
  .pd_o   (pd_o),
  .dq_oe_o(dq_oe_o),
  .ready_o(ready_o)
);

// File: tb/tb_dram_init_seq.sv
`timescale 1ns/1ps
module tb_dram_init_seq;
  localparam int CLK_MHZ = 200, STABLE_US = 200, T_PDEX = 2, T_RSC = 2;
  localparam int T_REFC = 12, N_REF = 2, GATE_CLK = 200, ADDR_W = 14;
  localparam int S = CLK_MHZ * STABLE_US;
  localparam int E = S + T_PDEX;

  logic clk = 0, rst_ni = 0;
  logic [2:0] cas_lat = 3'b101, burst_len = 3'b010;
  logic burst_type = 1'b1, drv = 1'b1;
  logic [3:0] cmd;
  logic [1:0] ba;
  logic [ADDR_W-1:0] addr;
  logic pd, oe, ready;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_PDEX(T_PDEX), .T_RSC(T_RSC),
    .T_REFC(T_REFC), .N_REF(N_REF), .GATE_CLK(GATE_CLK), .ADDR_W(ADDR_W)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cas_lat_i(cas_lat), .burst_type_i(burst_type),
    .burst_len_i(burst_len), .drv_strength_i(drv), .cmd_o(cmd), .ba_o(ba),
    .addr_o(addr), .pd_o(pd), .dq_oe_o(oe), .ready_o(ready)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // R1: reset values
  task automatic check_reset();
    chk("R1", "pd", pd, 0);
    chk("R1", "oe", oe, 0);
    chk("R1", "ready", ready, 0);
    chk("R1", "cmd", cmd, 4'b1111);
    chk("R1", "ba", ba, 0);
    chk("R1", "addr", addr, 0);
  endtask

  // Reference schedule evaluated for cycle t after reset release
  task automatic check_cycle(input int t);
    logic [3:0] e_cmd = 4'b1111;
    logic [1:0] e_ba = 2'b00;
    logic [ADDR_W-1:0] e_addr = '0;
    string tag = (t < S) ? "R2" : (t < E) ? "R3" : "R10";
    int ref_start = E + 2 * T_RSC;
    int ref_end = ref_start + N_REF * T_REFC;
    int rdy_at = (E + GATE_CLK > ref_end) ? E + GATE_CLK : ref_end;
    if (t == E) begin
      tag = "R4"; e_cmd = 4'b0000; e_ba = 2'b01; e_addr[1] = drv;
    end else if (t == E + T_RSC) begin
      tag = "R5"; e_cmd = 4'b0000;
      e_addr[2:0] = burst_len; e_addr[3] = burst_type; e_addr[6:4] = cas_lat;
    end else begin
      for (int k = 0; k < N_REF; k++)
        if (t == ref_start + k * T_REFC) begin tag = "R6"; e_cmd = 4'b0001; end
    end
    chk(tag, "cmd", cmd, e_cmd);
    chk(tag, "ba", ba, e_ba);
    chk(tag, "addr", addr, e_addr);
    chk((t < S) ? "R2" : "R3", "pd", pd, (t >= S) ? 1 : 0);
    chk("R8", "oe", oe, 0);
    chk((t > rdy_at) ? "R9" : "R7", "ready", ready, (t >= rdy_at) ? 1 : 0);
  endtask

  task automatic run(input int ncyc);
    for (int t = 0; t < ncyc; t++) begin
      check_cycle(t);
      @(negedge clk);
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_ni = 1'b1;
    #0.5;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    release_reset();
    // R9: abort partway through the stable wait, then restart
    run(1000);
    rst_ni = 1'b0;
    #0.5;
    check_reset();
    @(negedge clk);
    check_reset();
    release_reset();
    run(E + GATE_CLK + 60);
    // R9: second pass with different static fields
    rst_ni = 1'b0;
    cas_lat = 3'b011; burst_len = 3'b011; burst_type = 1'b0; drv = 1'b0;
    #0.5;
    check_reset();
    release_reset();
    run(E + GATE_CLK + 20);
    summary();
  end
endmodule